// File: doc/BRIEF.md
# Multi-cycle integer multiplier with sequencing controller

This block executes a processor's multiply instructions over several clock cycles. A small controller accepts a start strobe with the decoded mode bits and the source operands. It captures them into its own status registers and steps through a fixed schedule. In the first cycle it forms two 64-bit partial products. In the following cycle or two it folds them, together with an optional accumulate value, through one carry-save stage and a carry-propagate adder.

Plain 32-bit multiply and multiply-accumulate, and the signed 16x16 halfword multiplies, return one 32-bit word. Long multiplies, signed or unsigned and with or without a 64-bit accumulate, return the low word first and the high word one cycle later. The same adder serves both halves, and the low half's carry is kept in a register for the high half. An output-enable marks every cycle that carries a valid word. A one-cycle finish pulse tells the main pipeline controller that the next instruction may proceed. After each instruction the status registers are cleared, so no mode bit leaks into the next one.

Top module: `mul_seq_unit`

## Requirements
- R1: While reset is asserted and in the first cycles after it, `result_oe_o` and `done_o` are 0.
- R2: A start accepted at a clock edge while the unit is idle, with `long_i` = 0 and `dsp_i` = 0, presents in the second clock period after that edge `result_o` = low 32 bits of `op_a_i`*`op_b_i`, plus `op_c_i[31:0]` when `accum_i` = 1. `result_oe_o` and `done_o` are 1 in that same period.
- R3: A long multiply (`long_i` = 1, `dsp_i` = 0) presents the low 32 bits of the 64-bit product in the second period, with `result_oe_o` = 1 and `done_o` = 0. It presents the high 32 bits in the third period, with `result_oe_o` = 1 and `done_o` = 1. `signed_i` = 1 treats both operands as two's complement; `signed_i` = 0 treats them as unsigned.
- R4: A long multiply with `accum_i` = 1 adds the full 64-bit `op_c_i` to the 64-bit product before splitting it into the two words.
- R5: With `dsp_i` = 1, each operand is reduced to a signed 16-bit half. Select bit 1 takes bits 31:16 and select bit 0 takes bits 15:0 (`hsel_a_i` for A, `hsel_b_i` for B). The 32-bit signed product, plus `op_c_i[31:0]` when `accum_i` = 1, is returned in the second period. `long_i` is ignored in this mode.
- R6: `result_oe_o` is 0 in the first period after an accepted start and in every cycle without a result word. `done_o` is high for exactly one cycle per instruction, always together with `result_oe_o`.
- R7: A start strobe raised while an instruction is in progress is ignored: no extra result, no change to the running instruction's words or timing.
- R8: Mode bits are cleared after every instruction. A long multiply accepted in the first idle cycle after a halfword multiply returns its own low and high words, not the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| op_c_i | input | 64 | Accumulate value (low 32 bits for short results) |
| signed_i | input | 1 | 1: two's complement operands for long multiply |
| accum_i | input | 1 | 1: add the accumulate value |
| long_i | input | 1 | 1: 64-bit result over two words |
| dsp_i | input | 1 | 1: signed 16x16 halfword multiply |
| hsel_a_i | input | 1 | Halfword select for A (1 = upper) |
| hsel_b_i | input | 1 | Halfword select for B (1 = upper) |
| result_o | output | 32 | Result word |
| result_oe_o | output | 1 | Result word valid this cycle |
| done_o | output | 1 | One-cycle finish pulse |

## Verification
Counting from the clock edge that accepts a start, the first period never carries a result. The second period carries the only word of a short instruction, or the low word of a long one. The third period carries the high word of a long one, and the finish pulse falls in whichever period holds the last word. The bench's reference model pushes one expected entry per future period when it issues a start. It pops one entry at every falling edge and compares the enable, the finish pulse and, when enabled, the word, so a result that comes early, late or at an extra time is caught. Starts raised during a busy instruction push nothing, and a halfword multiply followed by a long one at the earliest idle cycle exercises the state clearing.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PP   = 2'd1,
    ST_LO   = 2'd2,
    ST_HI   = 2'd3
  } mstate_e;

  // Latched mode bits (status registers)
  typedef struct packed {
    logic sgn;
    logic acc;
    logic long_m;
    logic dsp;
    logic hsel_a;
    logic hsel_b;
  } mctl_t;

endpackage

// File: rtl/mul_ctrl_fsm.sv
module mul_ctrl_fsm
  import mul_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  mctl_t   ctl_i,
  output mstate_e state_o,
  output mctl_t   ctl_q_o,
  output logic    cap_o,
  output logic    pp_en_o,
  output logic    lo_en_o,
  output logic    hi_en_o,
  output logic    oe_o,
  output logic    done_o
);

  mstate_e state_q, state_d;
  mctl_t   ctl_q, ctl_d;
  logic    ctl_en;

  assign cap_o   = start_i && (state_q == ST_IDLE);
  assign pp_en_o = (state_q == ST_PP);
  assign lo_en_o = (state_q == ST_LO);
  assign hi_en_o = (state_q == ST_HI);
  assign oe_o    = lo_en_o || hi_en_o;
  assign done_o  = (lo_en_o && !ctl_q.long_m) || hi_en_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_PP;
      ST_PP:   state_d = ST_LO;
      ST_LO:   state_d = ctl_q.long_m ? ST_HI : ST_IDLE;
      ST_HI:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Mode capture; long mode is suppressed for halfword multiplies
  always_comb begin
    ctl_d  = ctl_q;
    ctl_en = 1'b0;
    if (cap_o) begin
      ctl_d        = ctl_i;
      ctl_d.long_m = ctl_i.long_m && !ctl_i.dsp;
      ctl_en       = 1'b1;
    end else if (done_o) begin
      ctl_d  = '0;
      ctl_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign state_o = state_q;
  assign ctl_q_o = ctl_q;

endmodule

// File: rtl/mul_pp_gen.sv
module mul_pp_gen
  import mul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic            pp_en_i,
  input  mctl_t           ctl_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [2*DW-1:0] pp0_o,
  output logic [2*DW-1:0] pp1_o
);

  localparam int PW = 2 * DW;
  localparam int HW = DW / 2;

  logic [DW-1:0] a_q, b_q;
  logic [PW-1:0] ext_w [2];
  logic [PW-1:0] pp0_d, pp1_d, hi_prod;
  logic [PW-1:0] pp0_q, pp1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (cap_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // Operand widening, one copy per operand
  for (genvar g = 0; g < 2; g++) begin : g_ext
    logic [DW-1:0] src;
    logic          sel;
    logic [HW-1:0] half;
    assign src  = (g == 0) ? a_q : b_q;
    assign sel  = (g == 0) ? ctl_i.hsel_a : ctl_i.hsel_b;
    assign half = sel ? src[DW-1:HW] : src[HW-1:0];
    always_comb begin
      if (ctl_i.dsp)      ext_w[g] = {{(PW-HW){half[HW-1]}}, half};
      else if (ctl_i.sgn) ext_w[g] = {{DW{src[DW-1]}}, src};
      else                ext_w[g] = {{DW{1'b0}}, src};
    end
  end

  // Two partial products: low 16 bits of B, and the rest of B shifted
  assign pp0_d   = ext_w[0] * {{(PW-HW){1'b0}}, ext_w[1][HW-1:0]};
  assign hi_prod = ext_w[0] * {{HW{1'b0}}, ext_w[1][PW-1:HW]};
  assign pp1_d   = hi_prod << HW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp0_q <= '0;
      pp1_q <= '0;
    end else if (pp_en_i) begin
      pp0_q <= pp0_d;
      pp1_q <= pp1_d;
    end
  end

  assign pp0_o = pp0_q;
  assign pp1_o = pp1_q;

endmodule

// File: rtl/mul_csa_add.sv
module mul_csa_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic [1:0]   cin_i,
  output logic [W-1:0] sum_o,
  output logic [1:0]   cout_o
);

  logic [W-1:0] s_w, c_w;
  logic [W+1:0] total;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_w[i] = x_i[i] ^ y_i[i] ^ z_i[i];
    assign c_w[i] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
  end

  assign total  = {2'b00, s_w} + {1'b0, c_w, 1'b0} + {{W{1'b0}}, cin_i};
  assign sum_o  = total[W-1:0];
  assign cout_o = total[W+1:W];

endmodule

// File: rtl/mul_sum_path.sv
module mul_sum_path
  import mul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic            lo_en_i,
  input  logic            hi_en_i,
  input  mctl_t           ctl_i,
  input  logic [2*DW-1:0] c_i,
  input  logic [2*DW-1:0] pp0_i,
  input  logic [2*DW-1:0] pp1_i,
  output logic [DW-1:0]   sum_o,
  output logic [DW-1:0]   res_q_o
);

  localparam int PW = 2 * DW;

  logic [PW-1:0] c_q;
  logic [1:0]    carry_q;
  logic [DW-1:0] res_q;
  logic [DW-1:0] x_w, y_w, z_w, sum_w;
  logic [1:0]    cin_w, cout_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    c_q <= '0;
    else if (cap_i) c_q <= c_i;
  end

  // One shared adder: low words in the LO cycle, high words in the HI cycle
  assign x_w   = hi_en_i ? pp0_i[PW-1:DW] : pp0_i[DW-1:0];
  assign y_w   = hi_en_i ? pp1_i[PW-1:DW] : pp1_i[DW-1:0];
  assign z_w   = !ctl_i.acc ? '0 : (hi_en_i ? c_q[PW-1:DW] : c_q[DW-1:0]);
  assign cin_w = hi_en_i ? carry_q : 2'b00;

  mul_csa_add #(.W(DW)) i_add (
    .x_i   (x_w),
    .y_i   (y_w),
    .z_i   (z_w),
    .cin_i (cin_w),
    .sum_o (sum_w),
    .cout_o(cout_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      carry_q <= '0;
    else if (lo_en_i) carry_q <= cout_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 res_q <= '0;
    else if (lo_en_i || hi_en_i) res_q <= sum_w;
  end

  assign sum_o   = sum_w;
  assign res_q_o = res_q;

endmodule

// File: rtl/mul_seq_unit.sv
module mul_seq_unit
  import mul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DW-1:0]   op_a_i,
  input  logic [DW-1:0]   op_b_i,
  input  logic [2*DW-1:0] op_c_i,
  input  logic            signed_i,
  input  logic            accum_i,
  input  logic            long_i,
  input  logic            dsp_i,
  input  logic            hsel_a_i,
  input  logic            hsel_b_i,
  output logic [DW-1:0]   result_o,
  output logic            result_oe_o,
  output logic            done_o
);

  localparam int PW = 2 * DW;

  mctl_t         ctl_in, ctl_q;
  mstate_e       state_w;
  logic          cap_w, pp_en_w, lo_en_w, hi_en_w, oe_w, done_w;
  logic [PW-1:0] pp0_w, pp1_w;
  logic [DW-1:0] sum_w, res_q_w;

  always_comb begin
    ctl_in.sgn    = signed_i;
    ctl_in.acc    = accum_i;
    ctl_in.long_m = long_i;
    ctl_in.dsp    = dsp_i;
    ctl_in.hsel_a = hsel_a_i;
    ctl_in.hsel_b = hsel_b_i;
  end

  mul_ctrl_fsm i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ctl_i  (ctl_in),
    .state_o(state_w),
    .ctl_q_o(ctl_q),
    .cap_o  (cap_w),
    .pp_en_o(pp_en_w),
    .lo_en_o(lo_en_w),
    .hi_en_o(hi_en_w),
    .oe_o   (oe_w),
    .done_o (done_w)
  );

  mul_pp_gen #(.DW(DW)) i_pp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_w),
    .pp_en_i(pp_en_w),
    .ctl_i  (ctl_q),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .pp0_o  (pp0_w),
    .pp1_o  (pp1_w)
  );

  mul_sum_path #(.DW(DW)) i_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_w),
    .lo_en_i(lo_en_w),
    .hi_en_i(hi_en_w),
    .ctl_i  (ctl_q),
    .c_i    (op_c_i),
    .pp0_i  (pp0_w),
    .pp1_i  (pp1_w),
    .sum_o  (sum_w),
    .res_q_o(res_q_w)
  );

  assign result_o    = oe_w ? sum_w : res_q_w;
  assign result_oe_o = oe_w;
  assign done_o      = done_w;

endmodule

// File: rtl/mul_seq_chk.sv
module mul_seq_chk
  import mul_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    start_i,
  input logic    long_i,
  input logic    dsp_i,
  input logic    oe_i,
  input logic    done_i,
  input mstate_e state_i,
  input mctl_t   ctl_q_i
);

  logic accepted;
  assign accepted = start_i && (state_i == ST_IDLE);

  p_done_with_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> oe_i);

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_first_cycle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accepted |=> !oe_i);

  p_short_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepted && (!long_i || dsp_i)) |-> ##2 (oe_i && done_i));

  p_long_timing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepted && long_i && !dsp_i) |-> ##2 (oe_i && !done_i) ##1 (oe_i && done_i));

  p_busy_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |=> (state_i != ST_PP));

  p_mode_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (ctl_q_i == '0));

endmodule

bind mul_seq_unit mul_seq_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .long_i (long_i),
  .dsp_i  (dsp_i),
  .oe_i   (result_oe_o),
  .done_i (done_o),
  .state_i(state_w),
  .ctl_q_i(ctl_q)
);

// File: tb/test_mul_seq_unit.sv
module test_mul_seq_unit;

  typedef struct {
    logic [31:0] a, b;
    logic [63:0] c;
    bit sgn, acc, lng, dsp, sa, sb;
  } op_t;

  typedef struct {
    bit          oe, done;
    logic [31:0] res;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] op_a, op_b;
  logic [63:0] op_c;
  logic        sgn, acc, lng, dsp, sa, sb;
  logic [31:0] result;
  logic        result_oe, done;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];
  bit   was_idle;

  always #2 clk = ~clk;

  mul_seq_unit i_mul_seq_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .op_a_i(op_a), .op_b_i(op_b), .op_c_i(op_c),
    .signed_i(sgn), .accum_i(acc), .long_i(lng), .dsp_i(dsp),
    .hsel_a_i(sa), .hsel_b_i(sb),
    .result_o(result), .result_oe_o(result_oe), .done_o(done)
  );

  // Spec-level product: full 64-bit value per R2..R5
  function automatic logic [63:0] ref_val(op_t o);
    logic [63:0] ea, eb, p;
    logic [15:0] ha, hb;
    if (o.dsp) begin
      ha = o.sa ? o.a[31:16] : o.a[15:0];
      hb = o.sb ? o.b[31:16] : o.b[15:0];
      ea = {{48{ha[15]}}, ha};
      eb = {{48{hb[15]}}, hb};
      p  = ea * eb;
      if (o.acc) p = p + {32'd0, o.c[31:0]};
    end else begin
      ea = o.sgn ? {{32{o.a[31]}}, o.a} : {32'd0, o.a};
      eb = o.sgn ? {{32{o.b[31]}}, o.b} : {32'd0, o.b};
      p  = ea * eb;
      if (o.acc) p = p + (o.lng ? o.c : {32'd0, o.c[31:0]});
    end
    return p;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // One clock period: compare at the falling edge, then drive the next inputs
  task automatic cycle(input bit st, input op_t o, input string tag);
    exp_t e;
    @(negedge clk);
    was_idle = (exp_q.size() == 0);
    if (was_idle) begin
      e.oe = 0; e.done = 0; e.res = '0; e.tag = "R6";
    end else begin
      e = exp_q.pop_front();
    end
    chk(e.tag, "oe", {31'd0, result_oe}, {31'd0, e.oe});
    chk(e.tag, "done", {31'd0, done}, {31'd0, e.done});
    if (e.oe) chk(e.tag, "result", result, e.res);
    start = st;
    op_a = o.a; op_b = o.b; op_c = o.c;
    sgn = o.sgn; acc = o.acc; lng = o.lng; dsp = o.dsp; sa = o.sa; sb = o.sb;
    if (st && was_idle) begin
      logic [63:0] v;
      exp_t q;
      v = ref_val(o);
      q.oe = 0; q.done = 0; q.res = '0; q.tag = "R6";
      exp_q.push_back(q);
      if (o.lng && !o.dsp) begin
        q.oe = 1; q.done = 0; q.res = v[31:0];  q.tag = tag; exp_q.push_back(q);
        q.oe = 1; q.done = 1; q.res = v[63:32]; q.tag = tag; exp_q.push_back(q);
      end else begin
        q.oe = 1; q.done = 1; q.res = v[31:0];  q.tag = tag; exp_q.push_back(q);
      end
    end
  endtask

  task automatic drain();
    op_t z;
    z = '{default: '0};
    while (exp_q.size() != 0) cycle(0, z, "R6");
    cycle(0, z, "R6");
  endtask

  function automatic op_t mk(logic [31:0] a, logic [31:0] b, logic [63:0] c,
                             bit sg, bit ac, bit lg, bit ds, bit hs_a, bit hs_b);
    op_t o;
    o.a = a; o.b = b; o.c = c; o.sgn = sg; o.acc = ac; o.lng = lg;
    o.dsp = ds; o.sa = hs_a; o.sb = hs_b;
    return o;
  endfunction

  initial begin
    op_t o, o2;
    rst_n = 1'b0; start = 0; op_a = '0; op_b = '0; op_c = '0;
    sgn = 0; acc = 0; lng = 0; dsp = 0; sa = 0; sb = 0;
    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      chk("R1", "oe in reset", {31'd0, result_oe}, 32'd0);
      chk("R1", "done in reset", {31'd0, done}, 32'd0);
    end
    rst_n = 1'b1;
    drain();

    // R2: plain and accumulate
    cycle(1, mk(32'd7, 32'd6, 64'd0, 0, 0, 0, 0, 0, 0), "R2"); drain();
    cycle(1, mk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h1234_5678_8000_0001, 0, 1, 0, 0, 0, 0), "R2"); drain();
    // R3: unsigned and signed long
    cycle(1, mk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0, 0, 1, 0, 0, 0), "R3"); drain();
    cycle(1, mk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1, 0, 1, 0, 0, 0), "R3"); drain();
    cycle(1, mk(32'h8000_0000, 32'h7FFF_FFFF, 64'd0, 1, 0, 1, 0, 0, 0), "R3"); drain();
    // R4: long accumulate with carries out of the low word
    cycle(1, mk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1, 0, 0, 0), "R4"); drain();
    cycle(1, mk(32'hFFFF_FFFE, 32'h0000_0003, 64'h0000_0001_FFFF_FFFF, 1, 1, 1, 0, 0, 0), "R4"); drain();
    // R5: all four halfword selections, long bit set but ignored
    for (int k = 0; k < 4; k++) begin
      cycle(1, mk(32'h8000_7FFF, 32'hFFFF_8000, 64'h0000_0000_0000_0100,
                  0, k[0], 1, 1, k[0], k[1]), "R5");
      drain();
    end
    // R7: starts raised while busy are ignored
    o  = mk(32'h1234_5678, 32'h9ABC_DEF0, 64'h0, 0, 0, 1, 0, 0, 0);
    o2 = mk(32'h0000_0003, 32'h0000_0005, 64'h0, 0, 0, 0, 0, 0, 0);
    cycle(1, o, "R7");
    cycle(1, o2, "R7");
    cycle(1, o2, "R7");
    cycle(1, o2, "R7");
    o2.a = '0;
    cycle(0, o2, "R7");
    drain();
    // R8: long multiply at the first idle cycle after a halfword multiply
    cycle(1, mk(32'h7FFF_0002, 32'h0003_8000, 64'h0, 0, 0, 0, 1, 1, 0), "R8");
    o2 = mk(32'h0, 32'h0, 64'h0, 0, 0, 0, 0, 0, 0);
    cycle(0, o2, "R8");
    cycle(0, o2, "R8");
    cycle(1, mk(32'hDEAD_BEEF, 32'h0000_0010, 64'h0, 0, 0, 1, 0, 0, 0), "R8");
    drain();
    // Random mix, alternately drained and issued back to back
    for (int n = 0; n < 300; n++) begin
      o = mk($urandom, $urandom, {$urandom, $urandom}, 1'($urandom), 1'($urandom),
             1'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom));
      cycle(1, o, o.dsp ? "R5" : (o.lng ? (o.acc ? "R4" : "R3") : "R2"));
      if (n % 2 == 0) drain();
      else while (!was_idle) cycle(1, o, "R7");
    end
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule